// File: doc/BRIEF.md
# Indexed Address Translation Bridge

This block sits between a 32-bit host register bus and the request/acknowledge port of a storage controller core. The core's internal space is 28 bits wide, and the host may only have a small window for it. In indexed mode the window holds two registers. The host first writes the full internal address into a control register at window offset 0x00. It then reads or writes a data register at offset 0x10. Each data access becomes one internal read or write at the address held in the control register.

The internal address has three fields. The top two bits choose a map: 0 is raw buffer access, 1 is page streaming by programmed I/O, 2 is the high-level command plane, and 3 is direct device-cycle access. The next two bits name one of four banks. The remaining 24 bits form a low field: the page number in map 1 and the cycle type in map 3. The held address does not change between data accesses, so one control write is enough for a whole page stream. When the feature input turns indexed mode off, each host address is used directly as the internal address.

Top module: `idx_xlate_bridge`

## Requirements
- R1: After reset, `h_ready` and `c_req` are low and a control-register read returns zero.
- R2: In indexed mode, a host write to offset 0x00 stores `h_wdata[27:0]` as the held address and issues no internal request. A read of offset 0x00 returns the held address zero-extended to 32 bits.
- R3: In indexed mode, each host access to offset 0x10 issues exactly one internal request at the held address. `c_map` carries address bits 27:26, `c_bank` bits 25:24 and `c_low` bits 23:0.
- R4: `c_cyc` equals `c_low[1:0]` when `c_map` is 3 (0 = command, 1 = address, 2 = data cycle) and is 0 for maps 0 to 2.
- R5: `c_req` rises one clock edge after the host access is accepted. It stays high with stable fields until `c_ack`. `h_ready` stays low while `c_req` is high, then pulses one edge after the acknowledging edge. For a read, it returns `c_rdata` in that same transaction.
- R6: The held address is unchanged by data accesses. Consecutive data accesses all target the same address without a new control write.
- R7: With `idx_mode` low, every host access becomes an internal request at `h_addr[27:0]`, offsets 0x00 and 0x10 included, and the held address is left untouched.
- R8: In indexed mode, an access to any offset other than 0x00 and 0x10 completes one edge after acceptance. It issues no request, reads as zero and leaves the held address unchanged.
- R9: For a forwarded write, `c_we` is high and `c_wdata` equals `h_wdata`. For a forwarded read, `c_we` is low.
- R10: `h_ready` is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_mode | input | 1 | 1 selects the two-register window, 0 selects direct addressing |
| h_sel | input | 1 | Host access valid; held until `h_ready` |
| h_wr | input | 1 | Host access is a write |
| h_addr | input | 28 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with `h_ready` |
| h_ready | output | 1 | Host access complete (one-cycle pulse) |
| c_req | output | 1 | Internal request, held until `c_ack` |
| c_we | output | 1 | Internal request is a write |
| c_map | output | 2 | Map selector |
| c_bank | output | 2 | Target bank |
| c_low | output | 24 | Low address field (page number or cycle field) |
| c_cyc | output | 2 | Device cycle type in map 3, otherwise 0 |
| c_wdata | output | 32 | Internal write data |
| c_rdata | input | 32 | Internal read data, valid with `c_ack` |
| c_ack | input | 1 | Internal acknowledge |

## Verification
A forwarded access shows `c_req` and its fields one edge after the host raises `h_sel`. `h_ready` with read data is due one edge after the edge at which `c_ack` is sampled high. A control or unmapped access produces `h_ready` one edge after acceptance, with no request. The bench drives inputs on falling edges and counts each rising edge. It samples outputs at the falling edge after the edge where each result is due, and again one cycle later to confirm that `h_ready` has dropped. Acknowledge delays of zero and several cycles are used to test the hold window. A falling-edge monitor counts request starts against the bench's model and flags `h_ready` whenever it appears alongside `c_req`.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int IADDR_W = 28;
  localparam int MAP_W   = 2;
  localparam int BANK_W  = 2;
  localparam int LOW_W   = IADDR_W - MAP_W - BANK_W;
  localparam int CYC_W   = 2;
  localparam int DATA_W  = 32;

  localparam logic [MAP_W-1:0] MAP_DEVCYC = MAP_W'(3);

  typedef enum logic [1:0] {
    ACC_LOCAL   = 2'd0,
    ACC_CTRL_RD = 2'd1,
    ACC_CTRL_WR = 2'd2,
    ACC_FWD     = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [MAP_W-1:0]  map;
    logic [BANK_W-1:0] bank;
    logic [LOW_W-1:0]  low;
  } iaddr_t;

  // Split a flat internal address into its map, bank and low fields.
  function automatic iaddr_t split_iaddr(input logic [IADDR_W-1:0] a);
    iaddr_t t;
    t.map  = a[IADDR_W-1 -: MAP_W];
    t.bank = a[LOW_W + BANK_W - 1 -: BANK_W];
    t.low  = a[LOW_W-1:0];
    return t;
  endfunction

  // Device cycle type is only meaningful in the device-cycle map.
  function automatic logic [CYC_W-1:0] cycle_kind(input iaddr_t t);
    if (t.map == MAP_DEVCYC) return t.low[CYC_W-1:0];
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] widen_iaddr(input logic [IADDR_W-1:0] a);
    return {{(DATA_W-IADDR_W){1'b0}}, a};
  endfunction
endpackage

// File: rtl/xlate_classify.sv
module xlate_classify
  import xlate_pkg::*;
#(
  parameter int HADDR_W  = 28,
  parameter int CTRL_OFS = 'h00,
  parameter int DATA_OFS = 'h10
) (
  input  logic               idx_mode,
  input  logic               h_wr,
  input  logic [HADDR_W-1:0] h_addr,
  output acc_kind_e          kind
);
  localparam logic [HADDR_W-1:0] CTRL_A = HADDR_W'(CTRL_OFS);
  localparam logic [HADDR_W-1:0] DATA_A = HADDR_W'(DATA_OFS);

  always_comb begin
    if (!idx_mode)            kind = ACC_FWD;
    else if (h_addr == CTRL_A) kind = h_wr ? ACC_CTRL_WR : ACC_CTRL_RD;
    else if (h_addr == DATA_A) kind = ACC_FWD;
    else                       kind = ACC_LOCAL;
  end
endmodule

// File: rtl/xlate_ctrl_reg.sv
module xlate_ctrl_reg
  import xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [IADDR_W-1:0] din,
  output logic [IADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/xlate_seq.sv
module xlate_seq
  import xlate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [DATA_W-1:0]  h_wdata,
  input  acc_kind_e          kind,
  input  logic [IADDR_W-1:0] target,
  input  logic [IADDR_W-1:0] held_addr,
  input  logic               c_ack,
  input  logic [DATA_W-1:0]  c_rdata,
  output logic               accept,
  output logic               h_ready,
  output logic [DATA_W-1:0]  h_rdata,
  output logic               c_req,
  output logic               c_we,
  output iaddr_t             c_tgt,
  output logic [DATA_W-1:0]  c_wdata
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_RESP} st_e;
  st_e st;

  assign accept  = h_sel && (st == ST_IDLE);
  assign h_ready = (st == ST_RESP);
  assign c_req   = (st == ST_BUSY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      h_rdata <= '0;
      c_we    <= 1'b0;
      c_tgt   <= '0;
      c_wdata <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          case (kind)
            ACC_FWD: begin
              st      <= ST_BUSY;
              c_we    <= h_wr;
              c_tgt   <= split_iaddr(target);
              c_wdata <= h_wdata;
            end
            ACC_CTRL_RD: begin
              st      <= ST_RESP;
              h_rdata <= widen_iaddr(held_addr);
            end
            default: begin
              st      <= ST_RESP;
              h_rdata <= '0;
            end
          endcase
        end
        ST_BUSY: if (c_ack) begin
          st      <= ST_RESP;
          h_rdata <= c_we ? '0 : c_rdata;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/idx_xlate_bridge.sv
module idx_xlate_bridge
  import xlate_pkg::*;
#(
  parameter int HADDR_W  = 28,
  parameter int CTRL_OFS = 'h00,
  parameter int DATA_OFS = 'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               idx_mode,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0]  h_wdata,
  output logic [DATA_W-1:0]  h_rdata,
  output logic               h_ready,
  output logic               c_req,
  output logic               c_we,
  output logic [MAP_W-1:0]   c_map,
  output logic [BANK_W-1:0]  c_bank,
  output logic [LOW_W-1:0]   c_low,
  output logic [CYC_W-1:0]   c_cyc,
  output logic [DATA_W-1:0]  c_wdata,
  input  logic [DATA_W-1:0]  c_rdata,
  input  logic               c_ack
);
  acc_kind_e          acc_kind;
  logic               acc_start;
  logic               latch_load;
  logic [IADDR_W-1:0] latch_q;
  logic [IADDR_W-1:0] fwd_addr;
  iaddr_t             req_tgt;

  xlate_classify #(
    .HADDR_W (HADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .DATA_OFS(DATA_OFS)
  ) u_classify (
    .idx_mode(idx_mode),
    .h_wr    (h_wr),
    .h_addr  (h_addr),
    .kind    (acc_kind)
  );

  assign latch_load = acc_start && (acc_kind == ACC_CTRL_WR);

  xlate_ctrl_reg u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .load (latch_load),
    .din  (h_wdata[IADDR_W-1:0]),
    .q    (latch_q)
  );

  assign fwd_addr = idx_mode ? latch_q : h_addr[IADDR_W-1:0];

  xlate_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_sel    (h_sel),
    .h_wr     (h_wr),
    .h_wdata  (h_wdata),
    .kind     (acc_kind),
    .target   (fwd_addr),
    .held_addr(latch_q),
    .c_ack    (c_ack),
    .c_rdata  (c_rdata),
    .accept   (acc_start),
    .h_ready  (h_ready),
    .h_rdata  (h_rdata),
    .c_req    (c_req),
    .c_we     (c_we),
    .c_tgt    (req_tgt),
    .c_wdata  (c_wdata)
  );

  assign c_map  = req_tgt.map;
  assign c_bank = req_tgt.bank;
  assign c_low  = req_tgt.low;
  assign c_cyc  = cycle_kind(req_tgt);
endmodule

// File: rtl/xlate_bridge_chk.sv
module xlate_bridge_chk
  import xlate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               idx_mode,
  input logic               h_ready,
  input logic               c_req,
  input logic               c_ack,
  input logic               c_we,
  input logic [MAP_W-1:0]   c_map,
  input logic [BANK_W-1:0]  c_bank,
  input logic [LOW_W-1:0]   c_low,
  input logic [DATA_W-1:0]  c_wdata,
  input logic               acc_start,
  input acc_kind_e          acc_kind,
  input logic [IADDR_W-1:0] latch_q
);
  p_ctrl_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && (acc_kind == ACC_CTRL_WR) |=> !c_req);

  p_fwd_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && (acc_kind == ACC_FWD) |=> c_req);

  p_held_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start && (acc_kind == ACC_FWD) && idx_mode |=>
      ({c_map, c_bank, c_low} == $past(latch_q)));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_req && !c_ack |=> c_req && $stable({c_we, c_map, c_bank, c_low, c_wdata}));

  p_ack_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_req && c_ack |=> h_ready && !c_req);

  p_no_ready_in_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_req |-> !h_ready);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    h_ready |=> !h_ready);
endmodule

bind idx_xlate_bridge xlate_bridge_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .idx_mode (idx_mode),
  .h_ready  (h_ready),
  .c_req    (c_req),
  .c_ack    (c_ack),
  .c_we     (c_we),
  .c_map    (c_map),
  .c_bank   (c_bank),
  .c_low    (c_low),
  .c_wdata  (c_wdata),
  .acc_start(acc_start),
  .acc_kind (acc_kind),
  .latch_q  (latch_q)
);

// File: tb/idx_xlate_bridge_test.sv
module idx_xlate_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_mode = 1'b1;
  logic        h_sel = 1'b0;
  logic        h_wr = 1'b0;
  logic [27:0] h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_ready;
  logic        c_req, c_we;
  logic [1:0]  c_map, c_bank, c_cyc;
  logic [23:0] c_low;
  logic [31:0] c_wdata;
  logic [31:0] c_rdata = '0;
  logic        c_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int req_seen = 0;
  int req_exp = 0;
  bit done = 1'b0;
  bit prev_req = 1'b0;

  always #2 clk = ~clk;

  idx_xlate_bridge uut (
    .clk(clk), .rst_n(rst_n), .idx_mode(idx_mode),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_ready(h_ready),
    .c_req(c_req), .c_we(c_we), .c_map(c_map), .c_bank(c_bank),
    .c_low(c_low), .c_cyc(c_cyc), .c_wdata(c_wdata),
    .c_rdata(c_rdata), .c_ack(c_ack)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Falling-edge model: counts request starts, ready must never join a request.
  always @(negedge clk) begin
    if (rst_n) begin
      if (c_req && !prev_req) req_seen++;
      if (c_req && h_ready) begin
        checks++; errors++;
        $display("FAIL R5 ready with request actual=1 expected=0");
      end
    end
    prev_req = c_req;
  end

  // One host access. fwd: a request at tgt is expected; dly: ack delay in cycles.
  task automatic access(input bit wr, input logic [27:0] addr, input logic [31:0] wd,
                        input bit fwd, input logic [27:0] tgt, input int dly,
                        input logic [31:0] resp, input logic [31:0] exp_rd,
                        input string tag);
    logic [1:0] exp_cyc;
    @(negedge clk);
    h_sel = 1'b1; h_wr = wr; h_addr = addr; h_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    if (fwd) begin
      req_exp++;
      exp_cyc = (tgt[27:26] == 2'd3) ? tgt[1:0] : 2'd0;
      check({tag, " R5 req"}, {31'd0, c_req}, 32'd1);
      check({tag, " R3 map"}, {30'd0, c_map}, {30'd0, tgt[27:26]});
      check({tag, " R3 bank"}, {30'd0, c_bank}, {30'd0, tgt[25:24]});
      check({tag, " R3 low"}, {8'd0, c_low}, {8'd0, tgt[23:0]});
      check({tag, " R4 cyc"}, {30'd0, c_cyc}, {30'd0, exp_cyc});
      check({tag, " R9 we"}, {31'd0, c_we}, {31'd0, wr});
      if (wr) check({tag, " R9 wdata"}, c_wdata, wd);
      for (int i = 0; i < dly; i++) begin
        @(posedge clk);
        @(negedge clk);
        check({tag, " R5 hold"}, {31'd0, c_req}, 32'd1);
        check({tag, " R5 hold low"}, {8'd0, c_low}, {8'd0, tgt[23:0]});
        check({tag, " R5 no ready"}, {31'd0, h_ready}, 32'd0);
      end
      c_ack = 1'b1; c_rdata = resp;
      @(posedge clk);
      @(negedge clk);
      c_ack = 1'b0; c_rdata = '0;
      check({tag, " R5 req drop"}, {31'd0, c_req}, 32'd0);
    end else begin
      check({tag, " R8 no req"}, {31'd0, c_req}, 32'd0);
    end
    check({tag, " R5 ready"}, {31'd0, h_ready}, 32'd1);
    check({tag, " R5 rdata"}, h_rdata, exp_rd);
    h_sel = 1'b0; h_wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R10 pulse"}, {31'd0, h_ready}, 32'd0);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 ready", {31'd0, h_ready}, 32'd0);
    check("R1 req", {31'd0, c_req}, 32'd0);
    access(1'b0, 28'h00, 32'h0, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R1 ctrl rd");

    // R2 control write drops top nibble, readback
    access(1'b1, 28'h00, 32'hF123_4567, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R2 ctrl wr");
    access(1'b0, 28'h00, 32'h0, 1'b0, 28'h0, 0, 32'h0, 32'h0123_4567, "R2 ctrl rd");

    // R3 data read map 0 bank 1, zero-delay ack
    access(1'b0, 28'h10, 32'h0, 1'b1, 28'h123_4567, 0, 32'hCAFE_0001, 32'hCAFE_0001, "R3 rd0");
    // R5 long ack delay
    access(1'b0, 28'h10, 32'h0, 1'b1, 28'h123_4567, 4, 32'h1234_ABCD, 32'h1234_ABCD, "R5 rd4");

    // R4 map 3 bank 2, address cycle
    access(1'b1, 28'h00, 32'h0E00_0001, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R4 set");
    access(1'b1, 28'h10, 32'h0000_0090, 1'b1, 28'hE00_0001, 1, 32'h0, 32'h0, "R4 addr cyc");
    access(1'b1, 28'h00, 32'h0E00_0002, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R4 set2");
    access(1'b1, 28'h10, 32'h0000_00AA, 1'b1, 28'hE00_0002, 0, 32'h0, 32'h0, "R4 data cyc");

    // R6 page stream in map 1, one control write, several data accesses
    access(1'b1, 28'h00, 32'h0400_00A5, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R6 set");
    for (int k = 0; k < 3; k++)
      access(1'b1, 28'h10, 32'h5A5A_0000 + k, 1'b1, 28'h400_00A5, k, 32'h0, 32'h0, "R6 R9 stream");
    access(1'b0, 28'h10, 32'h0, 1'b1, 28'h400_00A5, 2, 32'h8765_4321, 32'h8765_4321, "R6 stream rd");
    access(1'b0, 28'h00, 32'h0, 1'b0, 28'h0, 0, 32'h0, 32'h0400_00A5, "R6 ctrl kept");

    // R8 unmapped offsets
    access(1'b1, 28'h08, 32'hFFFF_FFFF, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R8 wr");
    access(1'b0, 28'h04, 32'h0, 1'b0, 28'h0, 0, 32'h0, 32'h0, "R8 rd");
    access(1'b0, 28'h00, 32'h0, 1'b0, 28'h0, 0, 32'h0, 32'h0400_00A5, "R8 ctrl kept");

    // R7 direct mode
    idx_mode = 1'b0;
    access(1'b1, 28'h00, 32'h0BAD_F00D, 1'b1, 28'h000_0000, 0, 32'h0, 32'h0, "R7 at 0");
    access(1'b0, 28'h10, 32'h0, 1'b1, 28'h000_0010, 1, 32'h0000_7777, 32'h0000_7777, "R7 at 10");
    access(1'b0, 28'hBC0_0010, 32'h0, 1'b1, 28'hBC0_0010, 3, 32'h5555_AAAA, 32'h5555_AAAA, "R7 wide");
    access(1'b1, 28'hF00_0003, 32'h1111_2222, 1'b1, 28'hF00_0003, 0, 32'h0, 32'h0, "R7 R4 map3");
    idx_mode = 1'b1;
    access(1'b0, 28'h00, 32'h0, 1'b0, 28'h0, 0, 32'h0, 32'h0400_00A5, "R7 latch kept");

    repeat (2) @(negedge clk);
    check("R3 request count", req_seen, req_exp);
    summary();
  end
endmodule